// File: doc/BRIEF.md
# Serial Chain Upset Error Checker

This block tests a long serial register chain for single-event upsets without keeping a copy of the data it sends. A free-running word generator emits consecutive integers. Each word is serialized most significant bit first and shifted through a parameterized run of single-bit register stages. At the far end the stream is rebuilt into whole words. Every rebuilt word is expected to equal the one before it plus one. Any word that breaks this rule counts as an upset. Every rebuilt word also counts toward a total, so a host can form the upset ratio from the two counts.

A marker bit travels beside each data bit and is set only on the first bit of a word. The receiver therefore finds word boundaries at the end of the chain however many stages there are, and needs no latency setting. The host controls a test with three pulses. Start begins emitting words. Stop lets the word being sent finish and then goes idle. Clear zeros both counts and drops the stored expected value. A fault-injection input inverts the data bit entering the chain, so the checker can be exercised without radiation.

Top module: `upset_chain_checker`

## Requirements
- R1: The generator emits one 32-bit word every 32 clock cycles, sent most significant bit first. Consecutive words differ by one. While start has not been given, no word is emitted.
- R2: A start pulse sampled at edge E0 makes the first word load at edge E0+1, and further words load every 32 edges while the block runs. A stop pulse sampled at edge E0+k (k >= 1) gives exactly (k-1)/32+1 emitted words, using integer division. So k=96 gives 3 words and k=97 gives 4.
- R3: With STAGES chain stages, the first word after a start pulse at edge E0 is counted at edge E0+33+STAGES, and not earlier. The receiver finds alignment from the marker bit alone.
- R4: A received word that differs from the previous received word plus one adds one to the upset count. A single flipped data bit in a word that has both a predecessor and a successor therefore adds exactly 2. A flip in the last word before stop adds exactly 1.
- R5: The first word received after a start or a clear only loads the expected value and is never compared. A flip in that first word adds exactly 1.
- R6: The total count increases by exactly one for every word received, whether or not the word matched.
- R7: Both counts are CNT_W bits wide and hold at all-ones instead of wrapping.
- R8: A clear pulse makes both counts read zero after the edge that samples it. Clear has priority over a word completing on that same edge.
- R9: After stop, words already in flight are still received and counted. After that, the counts stay constant.
- R10: After reset both counts are zero, and they stay zero while no start is given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse: begin emitting words and re-prime the receiver |
| stop_i | input | 1 | Pulse: finish the current word, then go idle (wins over start) |
| clear_i | input | 1 | Pulse: zero both counts and drop the expected value |
| inject_i | input | 1 | Inverts the data bit entering the chain while high |
| total_o | output | CNT_W | Saturating count of received words |
| upsets_o | output | CNT_W | Saturating count of mismatching words |

## Verification
The bench places injected flips in the first word, in a middle word and in the last word after a stop. A design that compared the priming word, or that did not carry the corrupted word forward as the new reference, would report 2 instead of 1, or 1 instead of 2. It places stop pulses on both sides of a word boundary (96 and 97 cycles), so a design that loses or gains a word at stop gives the wrong total. It checks that the first count appears at exactly 33 plus the chain length, which catches an off-by-one in the receiver's alignment. It holds the injection high for 300 words to drive both counts past the width of an 8-bit counter, and it issues a clear in the middle of a run. A counter that wraps, or a clear that lets a stale expected value through, shows up as a nonzero or wrong count.

// File: rtl/ucc_pkg.sv
package ucc_pkg;

    // One position of the serial chain: a data bit and its word marker.
    typedef struct packed {
        logic data;
        logic mark;
    } lane_t;

    typedef enum logic {
        SRC_IDLE  = 1'b0,
        SRC_SHIFT = 1'b1
    } src_state_e;

    typedef enum logic {
        RX_HUNT = 1'b0,
        RX_FILL = 1'b1
    } rx_state_e;

    // Combine a source lane with an injected inversion of its data bit.
    function automatic lane_t lane_flip(lane_t l, logic flip);
        lane_t r;
        r.data = l.data ^ flip;
        r.mark = l.mark;
        return r;
    endfunction

endpackage

// File: rtl/ucc_source.sv
module ucc_source
    import ucc_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  run_i,
    output lane_t lane_o
);
    localparam int unsigned IDX_W = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    src_state_e        state_q;
    logic [WORD_W-1:0] gen_q;
    logic [WORD_W-1:0] shreg_q;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SRC_IDLE;
            gen_q   <= '0;
            shreg_q <= '0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                SRC_IDLE: begin
                    if (run_i) begin
                        shreg_q <= gen_q;
                        gen_q   <= gen_q + 1'b1;
                        idx_q   <= '0;
                        state_q <= SRC_SHIFT;
                    end
                end
                default: begin
                    if (idx_q == LAST_IDX) begin
                        if (run_i) begin
                            shreg_q <= gen_q;
                            gen_q   <= gen_q + 1'b1;
                            idx_q   <= '0;
                        end else begin
                            state_q <= SRC_IDLE;
                        end
                    end else begin
                        shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
                        idx_q   <= idx_q + 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        lane_o.data = (state_q == SRC_SHIFT) && shreg_q[WORD_W-1];
        lane_o.mark = (state_q == SRC_SHIFT) && (idx_q == '0);
    end

    // R9/R1: an idle generator with no run request never starts a word
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == SRC_IDLE && !run_i) |=> !lane_o.mark);

    // R1: a word in progress is never cut short
    assert_word_whole_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == SRC_SHIFT && idx_q != LAST_IDX) |=> (state_q == SRC_SHIFT && !lane_o.mark));

endmodule

// File: rtl/ucc_chain.sv
module ucc_chain
    import ucc_pkg::*;
#(
    parameter int unsigned STAGES = 64
) (
    input  logic  clk,
    input  logic  rst,
    input  lane_t lane_i,
    output lane_t lane_o
);
    lane_t stage_q [STAGES];

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stage_q[0] <= '0;
                else     stage_q[0] <= lane_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
                end else begin
                    stage_q[0] <= lane_i;
                    for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign lane_o = stage_q[STAGES-1];

endmodule

// File: rtl/ucc_deser.sv
module ucc_deser
    import ucc_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  lane_t             lane_i,
    output logic              word_valid_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int unsigned IDX_W = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    rx_state_e         state_q;
    logic [WORD_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_HUNT;
            sh_q    <= '0;
            idx_q   <= '0;
        end else if (lane_i.mark) begin
            sh_q    <= {{(WORD_W-1){1'b0}}, lane_i.data};
            idx_q   <= IDX_W'(1);
            state_q <= RX_FILL;
        end else if (state_q == RX_FILL) begin
            sh_q  <= {sh_q[WORD_W-2:0], lane_i.data};
            idx_q <= idx_q + 1'b1;
            if (idx_q == LAST_IDX) state_q <= RX_HUNT;
        end
    end

    assign word_valid_o = (state_q == RX_FILL) && !lane_i.mark && (idx_q == LAST_IDX);
    assign word_o       = {sh_q[WORD_W-2:0], lane_i.data};

    // R3: completed words are separated by at least one cycle
    assert_align_gap_R3: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |=> !word_valid_o);

endmodule

// File: rtl/ucc_tally.sv
module ucc_tally #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              reprime_i,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [CNT_W-1:0]  total_o,
    output logic [CNT_W-1:0]  upsets_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [WORD_W-1:0] expect_q;
    logic              primed_q;
    logic [CNT_W-1:0]  total_q;
    logic [CNT_W-1:0]  upsets_q;
    logic              miss;

    assign miss = word_valid_i && primed_q && (word_i != expect_q);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            expect_q <= '0;
            primed_q <= 1'b0;
            total_q  <= '0;
            upsets_q <= '0;
        end else begin
            if (word_valid_i) begin
                expect_q <= word_i + 1'b1;
                primed_q <= 1'b1;
                if (total_q != CNT_MAX) total_q <= total_q + 1'b1;
            end
            if (miss && upsets_q != CNT_MAX) upsets_q <= upsets_q + 1'b1;
            if (reprime_i) primed_q <= 1'b0;
        end
    end

    assign total_o  = total_q;
    assign upsets_o = upsets_q;

    // R6: the total moves by at most one per cycle and never goes down unless cleared
    assert_total_step_R6: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> (total_o == $past(total_o) || total_o == $past(total_o) + 1'b1));

    // R7: a saturated count stays saturated
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (upsets_o == CNT_MAX && !clear_i) |=> upsets_o == CNT_MAX);

    // R4: upsets can never outnumber received words
    assert_upsets_bounded_R4: assert property (@(posedge clk) disable iff (rst)
        upsets_o <= total_o);

    // R8: clear empties both counts
    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (total_o == '0 && upsets_o == '0));

    // R5: an unprimed receiver never records an upset
    assert_prime_skip_R5: assert property (@(posedge clk) disable iff (rst)
        (!primed_q && !clear_i) |=> upsets_o == $past(upsets_o));

endmodule

// File: rtl/upset_chain_checker.sv
module upset_chain_checker
    import ucc_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned STAGES = 64,
    parameter int unsigned CNT_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             clear_i,
    input  logic             inject_i,
    output logic [CNT_W-1:0] total_o,
    output logic [CNT_W-1:0] upsets_o
);
    logic              run_q;
    lane_t             src_lane;
    lane_t             chain_in;
    lane_t             chain_out;
    logic              word_valid;
    logic [WORD_W-1:0] word;

    always_ff @(posedge clk) begin
        if (rst)          run_q <= 1'b0;
        else if (stop_i)  run_q <= 1'b0;
        else if (start_i) run_q <= 1'b1;
    end

    ucc_source #(.WORD_W(WORD_W)) u_source (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run_q),
        .lane_o (src_lane)
    );

    assign chain_in = lane_flip(src_lane, inject_i);

    ucc_chain #(.STAGES(STAGES)) u_chain (
        .clk    (clk),
        .rst    (rst),
        .lane_i (chain_in),
        .lane_o (chain_out)
    );

    ucc_deser #(.WORD_W(WORD_W)) u_deser (
        .clk          (clk),
        .rst          (rst),
        .lane_i       (chain_out),
        .word_valid_o (word_valid),
        .word_o       (word)
    );

    ucc_tally #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_tally (
        .clk          (clk),
        .rst          (rst),
        .clear_i      (clear_i),
        .reprime_i    (start_i),
        .word_valid_i (word_valid),
        .word_i       (word),
        .total_o      (total_o),
        .upsets_o     (upsets_o)
    );

    // R9: stop always ends the run request
    assert_stop_ends_R9: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> !run_q);

endmodule

// File: tb/upset_chain_checker_bench.sv
`timescale 1ns/1ps
module upset_chain_checker_bench;
    localparam int S  = 40;
    localparam int CW = 8;
    localparam int W  = 32;

    logic clk = 1'b0, rst = 1'b1;
    logic start = 1'b0, stop = 1'b0, clr = 1'b0, inj = 1'b0;
    logic [CW-1:0] total, ups;
    int checks = 0, fails = 0, pos = 0;

    always #2.5 clk = ~clk;

    upset_chain_checker #(.WORD_W(W), .STAGES(S), .CNT_W(CW)) u_upset_chain_checker (
        .clk(clk), .rst(rst), .start_i(start), .stop_i(stop), .clear_i(clr),
        .inject_i(inj), .total_o(total), .upsets_o(ups)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); pos++; endtask
    task automatic wait_to(int e); while (pos < e - 1) tick(); endtask
    task automatic launch(); pos = -1; start = 1'b1; tick(); start = 1'b0; endtask
    task automatic halt_at(int e); wait_to(e); stop = 1'b1; tick(); stop = 1'b0; endtask
    task automatic flip_at(int e); wait_to(e); inj = 1'b1; tick(); inj = 1'b0; endtask
    task automatic drain(); repeat (2 * W + S + 10) tick(); endtask
    task automatic do_clear(); clr = 1'b1; tick(); clr = 1'b0; endtask

    function automatic int words_for(int k); return (k - 1) / W + 1; endfunction
    function automatic int done_after(int n, int ec);
        int c = 0;
        for (int j = 0; j < n; j++) if (33 + S + 32 * j > ec) c++;
        return c;
    endfunction

    task automatic t_reset();
        chk("R10", "total after reset", int'(total), 0);
        chk("R10", "upsets after reset", int'(ups), 0);
        repeat (200) tick();
        chk("R10", "total idle no start", int'(total), 0);
    endtask

    task automatic t_latency_and_stop();
        do_clear();
        launch();
        wait_to(33 + S);
        chk("R3", "total one edge before first word", int'(total), 0);
        tick();
        chk("R3", "total at first word edge", int'(total), 1);
        halt_at(100);
        drain();
        chk("R6", "total for k=100", int'(total), words_for(100));
        chk("R1", "upsets clean run", int'(ups), 0);
        repeat (200) tick();
        chk("R9", "total stable after stop", int'(total), words_for(100));
    endtask

    task automatic t_boundary(int k);
        do_clear();
        launch();
        halt_at(k);
        drain();
        chk("R2", $sformatf("words for stop at k=%0d", k), int'(total), words_for(k));
        chk("R2", "no upsets at boundary", int'(ups), 0);
    endtask

    task automatic t_mid_flip();
        do_clear();
        launch();
        flip_at(100);
        halt_at(300);
        drain();
        chk("R4", "upsets for middle flip", int'(ups), 2);
        chk("R6", "total with middle flip", int'(total), words_for(300));
        do_clear();
        chk("R8", "upsets zero after clear", int'(ups), 0);
        chk("R8", "total zero after clear", int'(total), 0);
    endtask

    task automatic t_first_flip();
        do_clear();
        launch();
        flip_at(10);
        halt_at(300);
        drain();
        chk("R5", "upsets for first-word flip", int'(ups), 1);
    endtask

    task automatic t_last_flip();
        do_clear();
        launch();
        flip_at(80);
        halt_at(96);
        drain();
        chk("R4", "upsets for last-word flip", int'(ups), 1);
        chk("R4", "total with last-word flip", int'(total), 3);
    endtask

    task automatic t_clear_mid();
        do_clear();
        launch();
        wait_to(150);
        clr = 1'b1; tick(); clr = 1'b0;
        chk("R8", "total right after mid clear", int'(total), 0);
        halt_at(400);
        drain();
        chk("R5", "no upset after clear priming", int'(ups), 0);
        chk("R8", "words counted after clear", int'(total), done_after(words_for(400), 150));
    endtask

    task automatic t_saturate();
        do_clear();
        inj = 1'b1;
        launch();
        halt_at(32 * 300);
        drain();
        inj = 1'b0;
        chk("R7", "total saturates", int'(total), 255);
        chk("R7", "upsets saturate", int'(ups), 255);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        tick();
        t_reset();
        t_latency_and_stop();
        t_boundary(96);
        t_boundary(97);
        t_mid_flip();
        t_first_flip();
        t_last_flip();
        t_clear_mid();
        t_saturate();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule